// File: doc/BRIEF.md
# USB Packet Field Parser

This block sits behind a full-speed line decoder. That decoder has already done the NRZI decoding and removed the stuffed bits. It hands over one data bit per `bit_vld_i` pulse, least-significant bit first, and frames each packet with a start strobe and an end strobe.

The parser assembles the bits into bytes and checks that the packet opens with the correct sync pattern. It validates and classifies the packet identifier, then pulls out the fields that belong to that packet class:

- **Tokens** yield a device address and an endpoint.
- **Start-of-frame** packets yield a frame number.
- **Data packets** stream their payload bytes out one at a time. The last two bytes are held back, because they are the 16-bit CRC.
- **Handshakes** carry nothing beyond the identifier.

The CRC bits of every packet are split off onto their own output and are not checked.

A consumer watches `pkt_done_o`. One cycle after the end strobe it can read the packet type, the identifier error flag, the sync error flag and the decoded fields. All of these stay put until the next start strobe. Payload bytes arrive earlier, on `pay_vld_o`, while the packet is still being received.

Top module: `usb_pkt_parser`

## Requirements
- R1: After reset, `pkt_type_o` is 0 (none), and `pid_err_o`, `sync_err_o`, `pkt_done_o`, `pay_vld_o`, all field outputs and `crc_o` are 0.
- R2: The first 8 bits of a packet are the sync field. Taken LSB first they must form the value 0x80, which means seven 0 bits followed by a 1. Any other value sets `sync_err_o`. The flag is cleared by the next start strobe.
- R3: Bits 8 to 15 form the identifier byte, LSB first. It maps onto `pkt_type_o` as follows:

  | Identifier | Packet | `pkt_type_o` |
  |---|---|---|
  | 0xE1 | OUT | 1 |
  | 0x69 | IN | 2 |
  | 0xA5 | SOF | 3 |
  | 0x2D | SETUP | 4 |
  | 0xC3 | DATA0 | 5 |
  | 0x4B | DATA1 | 6 |
  | 0xD2 | ACK | 7 |
  | 0x5A | NAK | 8 |
  | 0x1E | STALL | 9 |
  | 0x96 | NYET | 10 |

- R4: An identifier whose upper nibble is not the bitwise inverse of its lower nibble sets `pid_err_o` and gives type 15. A well-formed identifier that is not in the R3 table gives type 14 with `pid_err_o` low.
- R5: For an OUT, IN or SETUP token, the 16 bits after the identifier are unpacked once all 16 have arrived, counting from the first of them:
  - bits 0 to 6 are the address, on `dev_addr_o`;
  - bits 7 to 10 are the endpoint, on `endp_o`;
  - bits 11 to 15 are the CRC5, on `crc_o[4:0]`, with the upper bits of `crc_o` at zero.

  A token that ends before all 16 bits have arrived leaves these outputs at zero.
- R6: For a start-of-frame packet, the first 11 bits after the identifier are the frame number, on `frame_o`. The next 5 bits are the CRC5, on `crc_o[4:0]`.
- R7: In a data packet, every complete byte after the identifier except the last two appears on `pay_byte_o` with a one-cycle `pay_vld_o` pulse, in order. At the end strobe the final two bytes go to `crc_o`, with the first of them in the low byte.
- R8: A handshake packet produces no payload pulses, and its address, endpoint, frame and CRC outputs read 0.
- R9: `pkt_done_o` is high for exactly one cycle, the cycle after an end strobe is sampled while a packet is open. An end strobe with no packet open has no effect.
- R10: A start strobe clears the type, both error flags, the fields and `crc_o`. These outputs then change only while packet bits arrive. Bits that arrive with no packet open, after an end strobe and before the next start strobe, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sop_i | input | 1 | Packet start strobe |
| bit_vld_i | input | 1 | Qualifies `bit_i` for one cycle |
| bit_i | input | 1 | Destuffed data bit, LSB first |
| eop_i | input | 1 | Packet end strobe |
| pkt_type_o | output | 4 | Packet class code (R3, R4) |
| pid_err_o | output | 1 | Identifier check failed |
| sync_err_o | output | 1 | Sync field was not 0x80 |
| dev_addr_o | output | 7 | Token device address |
| endp_o | output | 4 | Token endpoint |
| frame_o | output | 11 | Start-of-frame number |
| crc_o | output | 16 | Separated CRC bits (CRC5 or CRC16) |
| pay_vld_o | output | 1 | Payload byte strobe |
| pay_byte_o | output | 8 | Payload byte |
| pkt_done_o | output | 1 | One-cycle packet completion pulse |

## Verification
Tokens are sent with an all-ones address and endpoint, with an all-zero pair, and with a mixed pair, so that a swapped or shifted field boundary shows up as a wrong value. Data packets with three payload bytes and with zero payload bytes separate a correct 16-bit hold-back from one that releases CRC bytes or swallows payload. Corrupted sync, a non-complementary identifier, a well-formed but unlisted identifier, a truncated token and stray bits sent between packets each check that one error path or ignore path stays confined to its own output.

// File: rtl/usb_pkt_parser.sv
module usb_pkt_parser #(
  parameter int ADDR_W  = 7,
  parameter int EP_W    = 4,
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sop_i,
  input  logic               bit_vld_i,
  input  logic               bit_i,
  input  logic               eop_i,
  output logic [3:0]         pkt_type_o,
  output logic               pid_err_o,
  output logic               sync_err_o,
  output logic [ADDR_W-1:0]  dev_addr_o,
  output logic [EP_W-1:0]    endp_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [15:0]        crc_o,
  output logic               pay_vld_o,
  output logic [7:0]         pay_byte_o,
  output logic               pkt_done_o
);

  localparam int FLD_W   = 16;
  localparam int CRC5_W  = FLD_W - ADDR_W - EP_W;
  localparam int SYNC_END = 7;
  localparam int PID_END  = 15;
  localparam int FLD_END  = PID_END + FLD_W;
  localparam int CNT_W    = $clog2(FLD_END + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FLD_END + 1);

  localparam logic [3:0] T_NONE  = 4'd0,  T_OUT   = 4'd1,  T_IN    = 4'd2;
  localparam logic [3:0] T_SOF   = 4'd3,  T_SETUP = 4'd4,  T_DATA0 = 4'd5;
  localparam logic [3:0] T_DATA1 = 4'd6,  T_ACK   = 4'd7,  T_NAK   = 4'd8;
  localparam logic [3:0] T_STALL = 4'd9,  T_NYET  = 4'd10, T_OTHER = 4'd14;
  localparam logic [3:0] T_BAD   = 4'd15;

  logic             active;
  logic [CNT_W-1:0] hcnt;
  logic [2:0]       ph;
  logic [7:0]       sr;
  logic [FLD_W-1:0] fld;
  logic [7:0]       h0, h1;
  logic [1:0]       nh;
  logic             is_data;

  wire             take     = active & bit_vld_i & ~eop_i & ~sop_i;
  wire [7:0]       nb       = {bit_i, sr[7:1]};
  wire [FLD_W-1:0] nf       = {bit_i, fld[FLD_W-1:1]};
  wire             byte_end = take && (ph == 3'd7);
  wire             in_body  = hcnt > CNT_W'(PID_END);
  wire             pid_ok   = nb[7:4] == ~nb[3:0];

  function automatic logic [3:0] classify(input logic [7:0] p);
    if (p[7:4] != ~p[3:0]) return T_BAD;
    case (p)
      8'hE1:   return T_OUT;
      8'h69:   return T_IN;
      8'hA5:   return T_SOF;
      8'h2D:   return T_SETUP;
      8'hC3:   return T_DATA0;
      8'h4B:   return T_DATA1;
      8'hD2:   return T_ACK;
      8'h5A:   return T_NAK;
      8'h1E:   return T_STALL;
      8'h96:   return T_NYET;
      default: return T_OTHER;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      hcnt       <= '0;
      ph         <= '0;
      sr         <= '0;
      fld        <= '0;
      h0         <= '0;
      h1         <= '0;
      nh         <= '0;
      is_data    <= 1'b0;
      pkt_type_o <= T_NONE;
      pid_err_o  <= 1'b0;
      sync_err_o <= 1'b0;
      dev_addr_o <= '0;
      endp_o     <= '0;
      frame_o    <= '0;
      crc_o      <= '0;
      pay_vld_o  <= 1'b0;
      pay_byte_o <= '0;
      pkt_done_o <= 1'b0;
    end else begin
      pay_vld_o  <= 1'b0;
      pkt_done_o <= 1'b0;
      if (sop_i) begin
        active     <= 1'b1;
        hcnt       <= '0;
        ph         <= '0;
        nh         <= '0;
        is_data    <= 1'b0;
        pkt_type_o <= T_NONE;
        pid_err_o  <= 1'b0;
        sync_err_o <= 1'b0;
        dev_addr_o <= '0;
        endp_o     <= '0;
        frame_o    <= '0;
        crc_o      <= '0;
      end else if (eop_i) begin
        if (active) begin
          active     <= 1'b0;
          pkt_done_o <= 1'b1;
          if (is_data && nh == 2'd2) crc_o <= {h1, h0};
        end
      end else if (take) begin
        ph <= ph + 3'd1;
        sr <= nb;
        if (hcnt != CNT_SAT) hcnt <= hcnt + 1'b1;
        if (in_body) fld <= nf;
        if (hcnt == CNT_W'(SYNC_END)) sync_err_o <= (nb != 8'h80);
        if (hcnt == CNT_W'(PID_END)) begin
          pkt_type_o <= classify(nb);
          pid_err_o  <= !pid_ok;
          is_data    <= (nb == 8'hC3) || (nb == 8'h4B);
        end
        if (hcnt == CNT_W'(FLD_END)) begin
          case (pkt_type_o)
            T_OUT, T_IN, T_SETUP: begin
              dev_addr_o <= nf[ADDR_W-1:0];
              endp_o     <= nf[ADDR_W +: EP_W];
              crc_o      <= 16'(nf[FLD_W-1 -: CRC5_W]);
            end
            T_SOF: begin
              frame_o <= nf[FRAME_W-1:0];
              crc_o   <= 16'(nf[FLD_W-1 -: (FLD_W - FRAME_W)]);
            end
            default: ;
          endcase
        end
        if (is_data && byte_end && in_body) begin
          case (nh)
            2'd0: begin
              h0 <= nb;
              nh <= 2'd1;
            end
            2'd1: begin
              h1 <= nb;
              nh <= 2'd2;
            end
            default: begin
              pay_vld_o  <= 1'b1;
              pay_byte_o <= h0;
              h0         <= h1;
              h1         <= nb;
            end
          endcase
        end
      end
    end
  end

endmodule

module usb_pkt_parser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sop_i,
  input logic       bit_vld_i,
  input logic       eop_i,
  input logic [3:0] pkt_type_o,
  input logic       pid_err_o,
  input logic       sync_err_o,
  input logic [6:0] dev_addr_o,
  input logic [3:0] endp_o,
  input logic [10:0] frame_o,
  input logic       pay_vld_o,
  input logic       pkt_done_o
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done_o |=> !pkt_done_o); // R9

  AST_DONE_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done_o |-> $past(eop_i)); // R9

  AST_PAY_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pay_vld_o |-> (pkt_type_o == 4'd5 || pkt_type_o == 4'd6)); // R7

  AST_SOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sop_i |=> (pkt_type_o == 4'd0 && !sync_err_o && !pid_err_o && dev_addr_o == 7'd0)); // R10

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sop_i && !bit_vld_i) |=> ($stable(pkt_type_o) && $stable(dev_addr_o) &&
                                $stable(endp_o) && $stable(frame_o))); // R10

  AST_PIDERR_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    pid_err_o |-> pkt_type_o == 4'd15); // R4

endmodule

bind usb_pkt_parser usb_pkt_parser_chk u_chk (.*);

// File: tb/usb_pkt_parser_tb.sv
module usb_pkt_parser_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sop = 1'b0, bvld = 1'b0, bdat = 1'b0, eop = 1'b0;
  logic [3:0]  pkt_type;
  logic        pid_err, sync_err, pay_vld, pkt_done;
  logic [6:0]  dev_addr;
  logic [3:0]  endp;
  logic [10:0] frame;
  logic [15:0] crc;
  logic [7:0]  pay_byte;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] txb[$];
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_pkt_parser u_dut (
    .clk(clk), .rst_n(rst_n), .sop_i(sop), .bit_vld_i(bvld), .bit_i(bdat),
    .eop_i(eop), .pkt_type_o(pkt_type), .pid_err_o(pid_err),
    .sync_err_o(sync_err), .dev_addr_o(dev_addr), .endp_o(endp),
    .frame_o(frame), .crc_o(crc), .pay_vld_o(pay_vld),
    .pay_byte_o(pay_byte), .pkt_done_o(pkt_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every payload strobe is compared with the oldest expected byte
  always @(negedge clk) begin
    if (rst_n && pay_vld) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R7 unexpected payload act=%0h exp=none", pay_byte);
      end else begin
        chk("R7 payload byte", {24'd0, pay_byte}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic xmit();
    sop = 1'b1;
    @(negedge clk);
    sop = 1'b0;
    foreach (txb[k]) begin
      for (int i = 0; i < 8; i++) begin
        bvld = 1'b1;
        bdat = txb[k][i];
        @(negedge clk);
      end
    end
    bvld = 1'b0;
    eop = 1'b1;
    @(negedge clk);
    eop = 1'b0;
    chk("R9 done pulse high", {31'd0, pkt_done}, 32'd1);
    @(negedge clk);
    chk("R9 done pulse single", {31'd0, pkt_done}, 32'd0);
  endtask

  task automatic token(input logic [7:0] pid, input logic [6:0] a, input logic [3:0] e,
                       input logic [4:0] c);
    logic [15:0] f;
    f = {c, e, a};
    txb = {8'h80, pid, f[7:0], f[15:8]};
    xmit();
  endtask

  task automatic data_pkt(input logic [7:0] pid, input logic [7:0] pl[$], input logic [15:0] c);
    txb = {8'h80, pid};
    foreach (pl[k]) begin
      txb.push_back(pl[k]);
      exp_q.push_back(pl[k]);
    end
    txb.push_back(c[7:0]);
    txb.push_back(c[15:8]);
    xmit();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pl[$];
    repeat (3) @(negedge clk);
    chk("R1 type", {28'd0, pkt_type}, 32'd0);
    chk("R1 flags", {28'd0, pid_err, sync_err, pkt_done, pay_vld}, 32'd0);
    chk("R1 fields", {10'd0, dev_addr, endp, frame}, 32'd0);
    chk("R1 crc", {16'd0, crc}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    token(8'hE1, 7'h15, 4'h3, 5'h1A);
    chk("R3 OUT type", {28'd0, pkt_type}, 32'd1);
    chk("R5 OUT addr", {25'd0, dev_addr}, 32'h15);
    chk("R5 OUT ep", {28'd0, endp}, 32'h3);
    chk("R5 OUT crc5", {16'd0, crc}, 32'h1A);
    chk("R2 good sync", {31'd0, sync_err}, 32'd0);
    chk("R4 good pid", {31'd0, pid_err}, 32'd0);

    repeat (5) @(negedge clk);
    chk("R10 hold addr", {25'd0, dev_addr}, 32'h15);

    token(8'h2D, 7'h7F, 4'hF, 5'h00);
    chk("R3 SETUP type", {28'd0, pkt_type}, 32'd4);
    chk("R5 SETUP addr", {25'd0, dev_addr}, 32'h7F);
    chk("R5 SETUP ep", {28'd0, endp}, 32'hF);
    chk("R5 SETUP crc5", {16'd0, crc}, 32'h0);

    token(8'h69, 7'h00, 4'h0, 5'h1F);
    chk("R3 IN type", {28'd0, pkt_type}, 32'd2);
    chk("R5 IN addr", {25'd0, dev_addr}, 32'h0);
    chk("R5 IN crc5", {16'd0, crc}, 32'h1F);

    token(8'hA5, 7'h23, 4'hB, 5'h11);
    chk("R3 SOF type", {28'd0, pkt_type}, 32'd3);
    chk("R6 frame", {21'd0, frame}, 32'h5A3);
    chk("R6 crc5", {16'd0, crc}, 32'h11);
    chk("R6 no addr", {25'd0, dev_addr}, 32'h0);

    pl = {8'h11, 8'h22, 8'h33};
    data_pkt(8'hC3, pl, 16'hBEEF);
    chk("R3 DATA0 type", {28'd0, pkt_type}, 32'd5);
    chk("R7 crc16", {16'd0, crc}, 32'hBEEF);
    chk("R7 all payload seen", exp_q.size(), 32'd0);

    pl = {};
    data_pkt(8'h4B, pl, 16'h1234);
    chk("R3 DATA1 type", {28'd0, pkt_type}, 32'd6);
    chk("R7 empty crc16", {16'd0, crc}, 32'h1234);

    pl = {8'hA0, 8'h05, 8'hFF, 8'h00, 8'h7E};
    data_pkt(8'h4B, pl, 16'h0F0F);
    chk("R7 crc16 longer", {16'd0, crc}, 32'h0F0F);
    chk("R7 all payload seen longer", exp_q.size(), 32'd0);

    token(8'hE1, 7'h2A, 4'h5, 5'h03);
    txb = {8'h80, 8'hD2};
    xmit();
    chk("R3 ACK type", {28'd0, pkt_type}, 32'd7);
    chk("R8 ACK fields cleared", {10'd0, dev_addr, endp, frame}, 32'd0);
    chk("R8 ACK crc", {16'd0, crc}, 32'd0);
    txb = {8'h80, 8'h5A};
    xmit();
    chk("R3 NAK type", {28'd0, pkt_type}, 32'd8);
    txb = {8'h80, 8'h1E};
    xmit();
    chk("R3 STALL type", {28'd0, pkt_type}, 32'd9);
    txb = {8'h80, 8'h96};
    xmit();
    chk("R3 NYET type", {28'd0, pkt_type}, 32'd10);

    txb = {8'h81, 8'hD2};
    xmit();
    chk("R2 bad sync flagged", {31'd0, sync_err}, 32'd1);
    chk("R2 type still decoded", {28'd0, pkt_type}, 32'd7);
    txb = {8'h80, 8'hD2};
    xmit();
    chk("R2 sync flag cleared", {31'd0, sync_err}, 32'd0);

    txb = {8'h80, 8'hE2};
    xmit();
    chk("R4 bad pid flag", {31'd0, pid_err}, 32'd1);
    chk("R4 bad pid type", {28'd0, pkt_type}, 32'd15);
    txb = {8'h80, 8'h3C};
    xmit();
    chk("R4 unlisted pid type", {28'd0, pkt_type}, 32'd14);
    chk("R4 unlisted pid no flag", {31'd0, pid_err}, 32'd0);

    txb = {8'h80, 8'hE1, 8'h55};
    xmit();
    chk("R5 truncated type", {28'd0, pkt_type}, 32'd1);
    chk("R5 truncated addr zero", {25'd0, dev_addr}, 32'd0);

    token(8'hE1, 7'h41, 4'h9, 5'h02);
    for (int i = 0; i < 24; i++) begin
      bvld = 1'b1;
      bdat = i[0];
      @(negedge clk);
    end
    bvld = 1'b0;
    eop = 1'b1;
    @(negedge clk);
    eop = 1'b0;
    chk("R9 stray eop no done", {31'd0, pkt_done}, 32'd0);
    chk("R10 stray bits addr", {25'd0, dev_addr}, 32'h41);
    chk("R10 stray bits ep", {28'd0, endp}, 32'h9);
    chk("R10 stray bits type", {28'd0, pkt_type}, 32'd1);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule